// File: doc/BRIEF.md
# Multi-Core Mailbox Doorbell Unit

The unit holds a bank of 32-bit mailboxes that processors use to raise software interrupts in one another. By default there are four cores with four mailboxes each, which makes sixteen mailboxes. A sender writes a bit pattern to a mailbox's set address, and the pattern is ORed into the stored word. The receiving core reads the mailbox through its clear address. It then acknowledges bits by writing them back to that same clear address, one bit or several at a time, and re-reads until the word is empty.

Any mailbox that holds a nonzero word raises a level request toward interrupt aggregation. Each core has a configuration register that routes each of its mailbox requests onto the core's IRQ line, its FIQ line, or neither. The register port is plain and has no back-pressure. A write strobe takes effect at the clock edge on which it is sampled. A read strobe returns data on `rd_data` one cycle later, and that data stays there until the next read.

Top module: `mbx_doorbell`

## Requirements
- R1: After reset every mailbox word and every configuration register is zero, `box_req`, `core_irq` and `core_fiq` are all low, and every read returns zero.
- R2: A write to byte address 0x80 + 16*c + 4*b ORs the write data into mailbox b of core c at that clock edge. All other mailboxes are unchanged.
- R3: A write to byte address 0xC0 + 16*c + 4*b clears the bits of mailbox b of core c that are 1 in the write data. Bits written as 0 keep their value.
- R4: A read of either the set address or the clear address of a mailbox returns that mailbox's 32-bit contents on `rd_data` in the cycle after the read strobe. `rd_data` holds its value while no read is strobed.
- R5: `box_req` bit 4*c + b is high exactly while mailbox b of core c is nonzero.
- R6: The configuration register of core c sits at byte address 0x50 + 4*c. Bit b enables IRQ routing of mailbox b, and bit b+4 enables FIQ routing of mailbox b. Bits 8 and above are ignored on write and read back as zero.
- R7: `core_irq[c]` is high exactly while some mailbox b of core c is nonzero, has its IRQ enable set, and has its FIQ enable clear.
- R8: `core_fiq[c]` is high exactly while some mailbox b of core c is nonzero and has its FIQ enable set. When both enables of a mailbox are set, its request reaches FIQ only.
- R9: Acknowledging one bit at a time through the clear address leaves the other bits set, and the request stays high until the last set bit is cleared.
- R10: Writes to addresses outside the set, clear and configuration windows change no state. A set write with all-zero data also changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 8 | Byte address of the access; bits 1:0 are ignored |
| wr_data | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| box_req | output | 16 | Per-mailbox nonzero request, index 4*core + mailbox |
| core_irq | output | 4 | IRQ line per core |
| core_fiq | output | 4 | FIQ line per core |

## Verification
The embedded properties assume a single-ported bus: at most one access per cycle, so `wr_en` and `rd_en` are never high together. Under that assumption a set and a clear of the same mailbox cannot land in the same cycle. The properties also assume the reset is held for at least one clock before the first access. The stimulus drives every access from a task that raises exactly one strobe for one cycle, on the falling edge. It samples results on the following falling edge.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_SET  = 2'd1,
    ACC_CLR  = 2'd2,
    ACC_CFG  = 2'd3
  } acc_kind_e;

  typedef struct packed {
    acc_kind_e  kind;
    logic [7:0] idx;
  } acc_dec_t;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NBOX     = 16,
  parameter int unsigned NCORE    = 4,
  parameter int unsigned SET_BASE = 32'h80,
  parameter int unsigned CLR_BASE = 32'hC0,
  parameter int unsigned CFG_BASE = 32'h50
) (
  input  logic [ADDR_W-1:0] addr,
  output mbx_pkg::acc_dec_t dec
);
  import mbx_pkg::*;

  localparam int unsigned SET_END = SET_BASE + NBOX * 4;
  localparam int unsigned CLR_END = CLR_BASE + NBOX * 4;
  localparam int unsigned CFG_END = CFG_BASE + NCORE * 4;

  logic [31:0] a;
  logic [31:0] off;

  always_comb begin
    a   = 32'(addr);
    off = '0;
    dec = '{kind: ACC_NONE, idx: 8'd0};
    if (a >= SET_BASE && a < SET_END) begin
      off      = a - SET_BASE;
      dec.kind = ACC_SET;
    end else if (a >= CLR_BASE && a < CLR_END) begin
      off      = a - CLR_BASE;
      dec.kind = ACC_CLR;
    end else if (a >= CFG_BASE && a < CFG_END) begin
      off      = a - CFG_BASE;
      dec.kind = ACC_CFG;
    end
    dec.idx = off[9:2];
  end
endmodule

// File: rtl/mbx_box.sv
module mbx_box #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic          clr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] value
);
  logic [DW-1:0] set_mask;
  logic [DW-1:0] clr_mask;

  assign set_mask = set_en ? wdata : '0;
  assign clr_mask = clr_en ? wdata : '0;

  // Clear is applied first, then set, so a bit hit by both ends up set.
  always_ff @(posedge clk) begin
    if (!rst_n) value <= '0;
    else        value <= (value & ~clr_mask) | set_mask;
  end

  p_set_sticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((value & $past(wdata)) == $past(wdata)));

  p_clear_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> ((value & $past(wdata)) == '0));

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !clr_en) |=> $stable(value));
endmodule

// File: rtl/mbx_route.sv
module mbx_route #(
  parameter int unsigned NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2*NB-1:0] cfg_wdata,
  input  logic [NB-1:0] req,
  output logic [2*NB-1:0] cfg,
  output logic          irq,
  output logic          fiq
);
  logic [NB-1:0] irq_en;
  logic [NB-1:0] fiq_en;
  logic [NB-1:0] to_irq;
  logic [NB-1:0] to_fiq;

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg <= '0;
    else if (cfg_we) cfg <= cfg_wdata;
  end

  assign irq_en = cfg[NB-1:0];
  assign fiq_en = cfg[2*NB-1:NB];

  genvar b;
  generate
    for (b = 0; b < NB; b++) begin : g_sel
      assign to_fiq[b] = req[b] & fiq_en[b];
      assign to_irq[b] = req[b] & irq_en[b] & ~fiq_en[b];
    end
  endgenerate

  assign irq = |to_irq;
  assign fiq = |to_fiq;

  p_irq_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|(req & irq_en & ~fiq_en)));

  p_both_go_fiq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(req & irq_en & fiq_en)) |-> fiq);
endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DW       = 32,
  parameter int unsigned NC       = 4,
  parameter int unsigned NB       = 4,
  parameter int unsigned SET_BASE = 32'h80,
  parameter int unsigned CLR_BASE = 32'hC0,
  parameter int unsigned CFG_BASE = 32'h50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DW-1:0]     rd_data,
  output logic [NC*NB-1:0]  box_req,
  output logic [NC-1:0]     core_irq,
  output logic [NC-1:0]     core_fiq
);
  import mbx_pkg::*;

  localparam int unsigned NBOX   = NC * NB;
  localparam int unsigned IDX_W  = (NBOX > 1) ? $clog2(NBOX) : 1;
  localparam int unsigned CORE_W = (NC > 1) ? $clog2(NC) : 1;
  localparam int unsigned CFG_W  = 2 * NB;

  acc_dec_t      dec;
  logic [DW-1:0] box_val [NBOX];
  logic [CFG_W-1:0] cfg_val [NC];
  logic [DW-1:0] rd_next;

  mbx_decode #(
    .ADDR_W(ADDR_W), .NBOX(NBOX), .NCORE(NC),
    .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE), .CFG_BASE(CFG_BASE)
  ) u_dec (
    .addr(addr),
    .dec (dec)
  );

  genvar c, b;
  generate
    for (c = 0; c < NC; c++) begin : g_core
      for (b = 0; b < NB; b++) begin : g_box
        localparam int unsigned I = c * NB + b;
        logic hit_set;
        logic hit_clr;
        assign hit_set = wr_en && dec.kind == ACC_SET && dec.idx == 8'(I);
        assign hit_clr = wr_en && dec.kind == ACC_CLR && dec.idx == 8'(I);

        mbx_box #(.DW(DW)) u_box (
          .clk   (clk),
          .rst_n (rst_n),
          .set_en(hit_set),
          .clr_en(hit_clr),
          .wdata (wr_data),
          .value (box_val[I])
        );
        assign box_req[I] = |box_val[I];
      end

      logic cfg_hit;
      assign cfg_hit = wr_en && dec.kind == ACC_CFG && dec.idx == 8'(c);

      mbx_route #(.NB(NB)) u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_hit),
        .cfg_wdata(wr_data[CFG_W-1:0]),
        .req      (box_req[c*NB +: NB]),
        .cfg      (cfg_val[c]),
        .irq      (core_irq[c]),
        .fiq      (core_fiq[c])
      );
    end
  endgenerate

  always_comb begin
    rd_next = '0;
    case (dec.kind)
      ACC_SET, ACC_CLR: rd_next = box_val[dec.idx[IDX_W-1:0]];
      ACC_CFG:          rd_next = {{(DW-CFG_W){1'b0}}, cfg_val[dec.idx[CORE_W-1:0]]};
      default:          rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

  p_rdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  p_cfg_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && dec.kind == ACC_CFG) |=> (rd_data[DW-1:CFG_W] == '0));
endmodule

// File: tb/mbx_doorbell_test.sv
module mbx_doorbell_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic [15:0] box_req;
  logic [3:0]  core_irq;
  logic [3:0]  core_fiq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [31:0] m_box [16];
  logic [7:0]  m_cfg [4];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #5 clk = ~clk;

  mbx_doorbell uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
    .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
    .box_req(box_req), .core_irq(core_irq), .core_fiq(core_fiq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [7:0] a);
    int ai = int'(a);
    if (ai >= 'h80 && ai < 'hC0) return m_box[(ai - 'h80) >> 2];
    if (ai >= 'hC0)              return m_box[(ai - 'hC0) >> 2];
    if (ai >= 'h50 && ai < 'h60) return {24'd0, m_cfg[(ai - 'h50) >> 2]};
    return 32'd0;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    int ai = int'(a);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    if (ai >= 'h80 && ai < 'hC0)      m_box[(ai - 'h80) >> 2] |= d;
    else if (ai >= 'hC0)              m_box[(ai - 'hC0) >> 2] &= ~d;
    else if (ai >= 'h50 && ai < 'h60) m_cfg[(ai - 'h50) >> 2] = d[7:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(model_read(a));
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk_outs(input string tag);
    logic [15:0] er;
    logic [3:0]  ei, ef;
    for (int c = 0; c < 4; c++) begin
      ei[c] = 1'b0; ef[c] = 1'b0;
      for (int b = 0; b < 4; b++) begin
        er[c*4+b] = (m_box[c*4+b] != 0);
        if (er[c*4+b] && m_cfg[c][b+4]) ef[c] = 1'b1;
        else if (er[c*4+b] && m_cfg[c][b]) ei[c] = 1'b1;
      end
    end
    chk({tag, " req R5"}, 32'(box_req), 32'(er));
    chk({tag, " irq R7"}, 32'(core_irq), 32'(ei));
    chk({tag, " fiq R8"}, 32'(core_fiq), 32'(ef));
  endtask

  // Monitor: pops one expected item per read strobe and compares a cycle later.
  initial begin
    forever begin
      @(posedge clk);
      if (rd_en) begin
        #1;
        if (exp_q.size() == 0) chk("R4 unexpected read", 32'd1, 32'd0);
        else chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) m_box[i] = '0;
    for (int i = 0; i < 4; i++)  m_cfg[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_outs("R1 reset");
    rd(8'hC0, "R1 box0 after reset");
    rd(8'h5C, "R1 cfg3 after reset");
    // R2 set and OR
    wr(8'h98, 32'h0000_00A5);
    chk_outs("R2 first set");
    rd(8'hD8, "R4 read clear addr");
    wr(8'h98, 32'h0000_0100);
    rd(8'h98, "R2 OR accumulate via set addr");
    // R3 clear only ones
    wr(8'hD8, 32'h0000_0005);
    rd(8'hD8, "R3 clear bits");
    wr(8'hD8, 32'h0000_0000);
    rd(8'hD8, "R3 zero clear no effect");
    // R6/R7 IRQ routing of core1 box2
    wr(8'h54, 32'h0000_0004);
    chk_outs("R7 irq route");
    rd(8'h54, "R6 cfg readback");
    // R8 both enables -> FIQ only, upper bits ignored
    wr(8'h54, 32'hFFFF_FF44);
    chk_outs("R8 both enabled");
    rd(8'h54, "R6 cfg upper ignored");
    wr(8'h54, 32'h0000_0040);
    chk_outs("R8 fiq only");
    wr(8'h54, 32'h0000_0000);
    chk_outs("R7 disabled");
    // R9 single-bit acknowledge loop on core1 box2 (contents 0x1A0)
    wr(8'h54, 32'h0000_0004);
    for (int bit_i = 0; bit_i < 32; bit_i++) begin
      if (m_box[6][bit_i]) begin
        wr(8'hD8, 32'd1 << bit_i);
        chk_outs("R9 ack step");
        rd(8'hD8, "R9 remaining bits");
      end
    end
    chk("R9 mailbox empty req", 32'(box_req[6]), 32'd0);
    // R10 ignored writes
    wr(8'h9C, 32'h0000_0003);
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h60, 32'hFFFF_FFFF);
    wr(8'h4C, 32'hFFFF_FFFF);
    wr(8'h80, 32'h0000_0000);
    chk_outs("R10 after unmapped writes");
    rd(8'h9C, "R10 neighbour intact");
    rd(8'hC0, "R10 zero set no effect");
    rd(8'h00, "R10 unmapped reads zero");
    // R2/R5 all sixteen mailboxes distinct, R8 on core3 with fiq+irq mix
    for (int i = 0; i < 16; i++) wr(8'(8'h80 + 4*i), 32'h1000_0000 + 32'(i*3 + 1));
    wr(8'h5C, 32'h0000_0093);
    chk_outs("R5 all boxes");
    for (int i = 0; i < 16; i++) rd(8'(8'hC0 + 4*i), "R2 per-box isolation");
    wr(8'hFC, 32'hFFFF_FFFF);
    chk_outs("R8 core3 after clearing box3");
    wr(8'hF0, 32'hFFFF_FFFF);
    chk_outs("R7 core3 irq left");
    repeat (3) @(negedge clk);
    chk("R4 all reads answered", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule